// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for every cycle of a four-word burst to a pipelined memory. A cycle with the step input low takes a fresh external address and starts a burst. A cycle with the step input high moves a small beat counter forward, and the counter changes only the low address bits. A static order input picks the beat order. In sequential order the low bits count up and wrap. In swizzled order the low bits are the start bits XORed with the beat number.

A clock enable freezes the whole block. A cycle with the step input low and the select input low ends any burst. The outputs are the current address and a flag that is set while a burst is open. The block has no data path, so nothing here is a valid/ready stream. Every pin is a plain control or status level and no back-pressure applies. The memory array and the data registers lie outside the block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `burst_active` is 0 and `addr_out` is all zeros.
- R2: A clock edge with `clk_en`=1, `advance`=0 and `select`=1 makes `addr_out` equal `addr_in` and sets `burst_active` to 1 from the next cycle.
- R3: With `interleave`=0, after k steps the low two bits of `addr_out` are (start + k) mod 4. The upper address bits keep the loaded value.
- R4: With `interleave`=1, after k steps the low two bits of `addr_out` are start XOR (k mod 4). The upper address bits keep the loaded value.
- R5: A step after the fourth beat returns to the first beat of the same four-word group. The burst stays active.
- R6: `interleave` is read without a clock. A change on it alters `addr_out` in the same cycle, using the beat count already reached.
- R7: While `clk_en`=0, `addr_out` and `burst_active` hold their values, whatever `advance`, `select` and `addr_in` do.
- R8: A clock edge with `clk_en`=1, `advance`=0 and `select`=0 clears `burst_active`. It also resets the beat count, so `addr_out` returns to the start address of the cancelled burst.
- R9: A clock edge with `clk_en`=1 and `advance`=1 while `burst_active`=0 changes neither `addr_out` nor `burst_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | 1 = cycle takes effect, 0 = all state holds |
| advance | input | 1 | 0 = load or deselect, 1 = step the beat counter |
| select | input | 1 | Sampled on load cycles: 1 = start a burst, 0 = cancel |
| interleave | input | 1 | Static order: 0 = sequential wrap, 1 = XOR order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | 1 while a burst is open |

## Verification
If the beat counter goes wrong, the low bits of `addr_out` drift from the arithmetic sequence on the first step after a load. A missing wrap appears on the fifth beat. A bad base register changes the upper bits, and that is visible on any beat. A fault in the hold or cancel logic changes `addr_out` or `burst_active` on the first edge where `clk_en` is low or a cancel is issued. Because the order select is combinational, an error in the order mapping appears in the same cycle that `interleave` changes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_STOP,
    OP_STEP,
    OP_IDLE
  } burst_op_e;

  function automatic burst_op_e decode_op(input logic en,
                                          input logic adv,
                                          input logic sel,
                                          input logic active);
    burst_op_e op;
    if (!en)            op = OP_HOLD;
    else if (!adv)      op = sel ? OP_LOAD : OP_STOP;
    else if (active)    op = OP_STEP;
    else                op = OP_IDLE;
    return op;
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              advance,
  input  logic              select,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              active_q
);

  burst_op_e op;

  always_comb op = decode_op(clk_en, advance, select, active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          base_q   <= addr_in;
          beat_q   <= '0;
          active_q <= 1'b1;
        end
        OP_STOP: begin
          beat_q   <= '0;
          active_q <= 1'b0;
        end
        OP_STEP: beat_q <= beat_q + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              interleave,
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] addr
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = base[BEAT_W-1:0] + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = base[b] ^ beat[b];
  end

  assign addr = {base[ADDR_W-1:BEAT_W], interleave ? xor_low : lin_low};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              advance,
  input  logic              select,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  burst_seq_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .advance  (advance),
    .select   (select),
    .addr_in  (addr_in),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .active_q (burst_active)
  );

  burst_order_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) map_i (
    .interleave (interleave),
    .base       (base_q),
    .beat       (beat_q),
    .addr       (addr_out)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              advance,
  input logic              select,
  input logic              interleave,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active
);

  logic [BEAT_W-1:0] low_plus1;
  assign low_plus1 = addr_out[BEAT_W-1:0] + 1'b1;

  a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !advance && select |=> burst_active && addr_out == $past(addr_in));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && burst_active && !interleave |=>
      (!interleave -> addr_out[BEAT_W-1:0] == $past(low_plus1)));

  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && burst_active |=>
      addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(burst_active) && ($stable(interleave) -> $stable(addr_out)));

  a_r8_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !advance && !select |=> !burst_active);

  a_r9_idle_step_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && !burst_active |=> !burst_active && $stable(addr_out));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_en       (clk_en),
  .advance      (advance),
  .select       (select),
  .interleave   (interleave),
  .addr_in      (addr_in),
  .addr_out     (addr_out),
  .burst_active (burst_active)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          advance = 1'b0;
  logic          select = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
    .select(select), .interleave(interleave), .addr_in(addr_in),
    .addr_out(addr_out), .burst_active(burst_active)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] act_a,
                       input logic [AW-1:0] exp_a, input logic act_b,
                       input logic exp_b);
    n_chk++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      n_bad++;
      $display("FAIL %s: addr=%h active=%0b expected addr=%h active=%0b",
               req, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic load(input logic [AW-1:0] a);
    clk_en = 1'b1; advance = 1'b0; select = 1'b1; addr_in = a;
    tick();
  endtask

  initial begin
    logic [AW-1:0] start;
    logic [1:0]    low;
    tick(); tick();
    check("R1 reset", addr_out, '0, burst_active, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", addr_out, '0, burst_active, 1'b0);

    // R2..R5 sweep: both orders, every start position, six beats
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        interleave = m[0];
        start = AW'(32'h5A3C0 + s * 32'h1D4 + s);
        start[1:0] = s[1:0];
        load(start);
        check("R2 load", addr_out, start, burst_active, 1'b1);
        advance = 1'b1;
        for (int k = 1; k <= 6; k++) begin
          tick();
          low = m[0] ? (s[1:0] ^ k[1:0]) : 2'(s + k);
          check(m[0] ? (k >= 4 ? "R4/R5 xor wrap" : "R4 xor step")
                     : (k >= 4 ? "R3/R5 linear wrap" : "R3 linear step"),
                addr_out, {start[AW-1:2], low}, burst_active, 1'b1);
        end
      end
    end

    // R6: order read without a clock
    interleave = 1'b0;
    start = 20'hABC81;
    load(start);
    advance = 1'b1;
    tick();
    check("R6 linear view", addr_out, 20'hABC82, burst_active, 1'b1);
    interleave = 1'b1; #1;
    check("R6 xor view", addr_out, 20'hABC80, burst_active, 1'b1);
    interleave = 1'b0; #1;
    check("R6 back to linear", addr_out, 20'hABC82, burst_active, 1'b1);

    // R7: suspend
    clk_en = 1'b0;
    advance = 1'b1; tick();
    check("R7 hold on step", addr_out, 20'hABC82, burst_active, 1'b1);
    advance = 1'b0; select = 1'b1; addr_in = 20'h12345; tick();
    check("R7 hold on load", addr_out, 20'hABC82, burst_active, 1'b1);
    select = 1'b0; tick();
    check("R7 hold on cancel", addr_out, 20'hABC82, burst_active, 1'b1);
    clk_en = 1'b1; advance = 1'b1; tick();
    check("R7 resumes", addr_out, 20'hABC83, burst_active, 1'b1);

    // R8: cancel
    advance = 1'b0; select = 1'b0; tick();
    check("R8 cancel", addr_out, start, burst_active, 1'b0);

    // R9: steps while idle
    advance = 1'b1; select = 1'b1;
    tick();
    check("R9 idle step", addr_out, start, burst_active, 1'b0);
    tick(); tick();
    check("R9 idle steps", addr_out, start, burst_active, 1'b0);
    interleave = 1'b1; tick();
    check("R9 idle step xor", addr_out, start, burst_active, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule